// File: doc/BRIEF.md
# Three-Level PWM Half-Bridge Gate Sequencer

This block is the digital core of a synchronous buck power stage. It receives an already decoded three-level PWM command and a three-level skip-mode command. It also receives an enable, a fault inhibit, a switch-node zero-cross flag, and an "is off" feedback bit for each power switch. From these it drives the high-side and low-side gate enables.

The block guarantees dead time between the two switches. A switch may only turn on after the opposite switch reports that it is off and a programmable number of clock cycles has then passed.

A mid PWM level can select one of two behaviours, chosen by skip mode:
- **Diode-emulation mode** (skip mode high or mid): the low side is held on through a blanking-plus-debounce window. The block then releases the low side on a zero cross.
- **Immediate-off mode** (skip mode low): both switches are dropped at once.

A falling skip-mode level while the low side conducts pulls the low side off.

All timing is in clock cycles. The blanking, debounce and dead-time counts are parameters.

The controller is a single state machine with these states:
- `ST_IDLE`: both switches off.
- `ST_HS_DEAD`: low side off, dead time running before high side on.
- `ST_HS_ON`: high side conducting.
- `ST_LS_DEAD`: high side off, dead time running before low side on.
- `ST_LS_ON`: low side conducting in continuous mode.
- `ST_SKIP_OFF`: low side forced off by a skip-mode fall.
- `ST_ZCD_DEAD`: dead time before the low side turns on for diode emulation.
- `ST_ZCD_WIN`: low side on inside the blanking-plus-debounce window.
- `ST_ZCD_WATCH`: low side on, waiting for the zero cross.
- `ST_ZCD_DONE`: zero cross seen, both switches off.

Transitions:
- Any state goes to `ST_IDLE` when inactive, or when skip mode is low with PWM at mid.
- A PWM high command leads through `ST_HS_DEAD` to `ST_HS_ON`.
- A PWM low command leads through `ST_LS_DEAD` to `ST_LS_ON`. From the window or watch states it goes straight to `ST_LS_ON`.
- A mid command in diode-emulation mode leads through `ST_ZCD_DEAD`, or directly from `ST_LS_ON`, into `ST_ZCD_WIN`.
- `ST_ZCD_WIN` moves to `ST_ZCD_DONE` or `ST_ZCD_WATCH` at window end.
- `ST_ZCD_WATCH` moves to `ST_ZCD_DONE` on the zero cross.
- A skip-mode fall takes the low-side-on states to `ST_SKIP_OFF`.

Top module: `hb_gate_seq`

## Requirements
- R1: While `rst_n` is low, and in any cycle in which `en` is low or `inhibit` is high, both gate outputs are 0. A cycle that follows an inactive cycle also has both gates 0.
- R2: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R3: For a PWM high command (`pwm_lvl` = 2'b10), `ls_gate` drops at the next clock edge. `hs_gate` rises only after `ls_off_fb` has been 1 for DEAD_CYC (default 2) consecutive cycles. With immediate feedback, `hs_gate` rises DEAD_CYC+1 edges after the command.
- R4: For a PWM low command (`pwm_lvl` = 2'b00), `hs_gate` drops at the next edge. `ls_gate` rises only after `hs_off_fb` has been 1 for DEAD_CYC consecutive cycles.
- R5: With skip mode non-low, a mid command (`pwm_lvl` = 2'b01 or 2'b11) turns the low side on after the dead time. If the low side is already on, the window starts at the next edge. The low side stays on for WIN_CYC = BLANK_CYC+DEBOUNCE_CYC cycles (default 25+8). It then turns off at the edge after `zc_flag` is seen.
- R6: A `zc_flag` seen inside the window is remembered and does not end the window early. The low side then turns off at the first edge after the window ends.
- R7: Skip mode mid (`skip_lvl` = 2'b01) gives exactly the same gate behaviour as skip mode high (2'b10 or 2'b11).
- R8: With skip mode low (`skip_lvl` = 2'b00) and a mid PWM command, both gates are 0 from the next edge on.
- R9: A falling skip-mode level (non-low to 2'b00) while the low side is on forces `ls_gate` to 0 at the next edge. With PWM low, the low side stays off until the PWM command changes, even if skip mode returns high.
- R10: Skip mode going low while the high side is on has no effect on either gate.
- R11: A PWM high command during the zero-current window aborts it. `ls_gate` drops at the next edge and `hs_gate` follows after the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Stage enable, active high |
| inhibit | input | 1 | Fault inhibit; forces both gates off |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 mid, 10 high, 11 mid |
| skip_lvl | input | 2 | Decoded skip-mode level: 00 low, 01 mid, 10/11 high |
| zc_flag | input | 1 | Switch-node zero-cross comparator flag |
| hs_off_fb | input | 1 | High-side switch reports off |
| ls_off_fb | input | 1 | Low-side switch reports off |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
Two functions can collide in the same cycle:
- The zero-cross flag arriving at the window expiry edge. The bench holds `zc_flag` high across a window that started from a conducting low side. It then expects `ls_gate` to fall on exactly the first edge after WIN_CYC cycles, neither earlier nor later.
- A PWM high abort landing inside an open window. The bench expects the low side to drop at once and the high side to follow only after the dead time.

Randomized PWM, skip-mode and zero-cross sequences are judged by a per-cycle overlap monitor. A held-low feedback input confirms that dead time counts only from reported turn-off.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    typedef enum logic [1:0] {
        CMD_HIGH    = 2'd0,
        CMD_LOW     = 2'd1,
        CMD_MID_ZCD = 2'd2,
        CMD_MID_OFF = 2'd3
    } hb_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_HS_DEAD   = 4'd1,
        ST_HS_ON     = 4'd2,
        ST_LS_DEAD   = 4'd3,
        ST_LS_ON     = 4'd4,
        ST_SKIP_OFF  = 4'd5,
        ST_ZCD_DEAD  = 4'd6,
        ST_ZCD_WIN   = 4'd7,
        ST_ZCD_WATCH = 4'd8,
        ST_ZCD_DONE  = 4'd9
    } hb_state_e;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
    import hb_seq_pkg::*;
(
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] skip_lvl,
    output hb_cmd_e    cmd
);

    always_comb begin
        unique case (pwm_lvl)
            LVL_HIGH: cmd = CMD_HIGH;
            LVL_LOW:  cmd = CMD_LOW;
            default:  cmd = (skip_lvl == LVL_LOW) ? CMD_MID_OFF : CMD_MID_ZCD;
        endcase
    end

endmodule

// File: rtl/hb_skip_edge.sv
module hb_skip_edge
    import hb_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] skip_lvl,
    output logic       skip_fall
);

    logic skip_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_low_q <= 1'b1;
        end else begin
            skip_low_q <= (skip_lvl == LVL_LOW);
        end
    end

    assign skip_fall = !skip_low_q && (skip_lvl == LVL_LOW);

endmodule

// File: rtl/hb_cycle_timer.sv
module hb_cycle_timer #(
    parameter int MAX_CNT = 33,
    localparam int TW     = $clog2(MAX_CNT + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);

    localparam logic [TW-1:0] CAP = TW'(MAX_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt < CAP) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_seq_pkg::*;
#(
    parameter int BLANK_CYC    = 25,
    parameter int DEBOUNCE_CYC = 8,
    parameter int DEAD_CYC     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       inhibit,
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] skip_lvl,
    input  logic       zc_flag,
    input  logic       hs_off_fb,
    input  logic       ls_off_fb,
    output logic       hs_gate,
    output logic       ls_gate
);

    localparam int WIN_CYC = BLANK_CYC + DEBOUNCE_CYC;
    localparam int TMAX    = (WIN_CYC > DEAD_CYC) ? WIN_CYC : DEAD_CYC;
    localparam int TW      = $clog2(TMAX + 1) + 1;
    localparam logic [TW-1:0] DEAD_LAST = TW'(DEAD_CYC - 1);
    localparam logic [TW-1:0] WIN_LAST  = TW'(WIN_CYC - 1);

    hb_state_e       state, nxt;
    hb_cmd_e         cmd;
    logic            skip_fall;
    logic            active;
    logic            tmr_clr;
    logic [TW-1:0]   tmr_cnt;
    logic            dead_done, win_done;
    logic            zc_seen;

    assign active    = en && !inhibit;
    assign dead_done = tmr_cnt >= DEAD_LAST;
    assign win_done  = tmr_cnt >= WIN_LAST;

    hb_cmd_decode u_dec (
        .pwm_lvl  (pwm_lvl),
        .skip_lvl (skip_lvl),
        .cmd      (cmd)
    );

    hb_skip_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .skip_lvl  (skip_lvl),
        .skip_fall (skip_fall)
    );

    hb_cycle_timer #(.MAX_CNT(TMAX)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr_cnt)
    );

    // zero-cross seen early inside the window is remembered until window end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_seen <= 1'b0;
        end else begin
            zc_seen <= (state == ST_ZCD_WIN) && (zc_seen || zc_flag);
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP_OFF, ST_ZCD_DONE, ST_HS_ON: begin
                    unique case (cmd)
                        CMD_HIGH:    nxt = (state == ST_HS_ON) ? ST_HS_ON : ST_HS_DEAD;
                        CMD_LOW:     nxt = (state == ST_SKIP_OFF) ? ST_SKIP_OFF : ST_LS_DEAD;
                        CMD_MID_ZCD: nxt = (state == ST_ZCD_DONE) ? ST_ZCD_DONE : ST_ZCD_DEAD;
                        CMD_MID_OFF: nxt = ST_IDLE;
                    endcase
                end
                ST_HS_DEAD: begin
                    unique case (cmd)
                        CMD_HIGH:    nxt = (ls_off_fb && dead_done) ? ST_HS_ON : ST_HS_DEAD;
                        CMD_LOW:     nxt = ST_LS_DEAD;
                        CMD_MID_ZCD: nxt = ST_ZCD_DEAD;
                        CMD_MID_OFF: nxt = ST_IDLE;
                    endcase
                end
                ST_LS_DEAD: begin
                    unique case (cmd)
                        CMD_HIGH:    nxt = ST_HS_DEAD;
                        CMD_LOW:     nxt = (hs_off_fb && dead_done) ? ST_LS_ON : ST_LS_DEAD;
                        CMD_MID_ZCD: nxt = ST_ZCD_DEAD;
                        CMD_MID_OFF: nxt = ST_IDLE;
                    endcase
                end
                ST_ZCD_DEAD: begin
                    unique case (cmd)
                        CMD_HIGH:    nxt = ST_HS_DEAD;
                        CMD_LOW:     nxt = ST_LS_DEAD;
                        CMD_MID_ZCD: nxt = (hs_off_fb && dead_done) ? ST_ZCD_WIN : ST_ZCD_DEAD;
                        CMD_MID_OFF: nxt = ST_IDLE;
                    endcase
                end
                ST_LS_ON, ST_ZCD_WIN, ST_ZCD_WATCH: begin
                    if (cmd == CMD_HIGH) begin
                        nxt = ST_HS_DEAD;
                    end else if (skip_fall) begin
                        nxt = ST_SKIP_OFF;
                    end else begin
                        unique case (cmd)
                            CMD_LOW:     nxt = ST_LS_ON;
                            CMD_MID_OFF: nxt = ST_IDLE;
                            default: begin
                                if (state == ST_LS_ON) begin
                                    nxt = ST_ZCD_WIN;
                                end else if (state == ST_ZCD_WIN) begin
                                    if (win_done) begin
                                        nxt = (zc_seen || zc_flag) ? ST_ZCD_DONE : ST_ZCD_WATCH;
                                    end
                                end else if (zc_flag) begin
                                    nxt = ST_ZCD_DONE;
                                end
                            end
                        endcase
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // timer restarts on every state change and while the awaited switch is still on
    always_comb begin
        tmr_clr = (nxt != state);
        unique case (state)
            ST_HS_DEAD:              if (!ls_off_fb) tmr_clr = 1'b1;
            ST_LS_DEAD, ST_ZCD_DEAD: if (!hs_off_fb) tmr_clr = 1'b1;
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs
    always_comb begin
        hs_gate = 1'b0;
        ls_gate = 1'b0;
        if (active) begin
            unique case (state)
                ST_HS_ON:                         hs_gate = 1'b1;
                ST_LS_ON, ST_ZCD_WIN, ST_ZCD_WATCH: ls_gate = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       inhibit,
    input logic [1:0] pwm_lvl,
    input logic [1:0] skip_lvl,
    input logic       hs_off_fb,
    input logic       ls_off_fb,
    input logic       hs_gate,
    input logic       ls_gate
);

    // R1
    inactive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en || inhibit) |-> (!hs_gate && !ls_gate));

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R3
    hs_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(ls_off_fb) && !$past(ls_gate)));

    // R4
    ls_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(hs_off_fb) && !$past(hs_gate)));

    // R8
    mid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(skip_lvl == 2'b00 && pwm_lvl[0]) |-> (!hs_gate && !ls_gate));

endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .inhibit   (inhibit),
    .pwm_lvl   (pwm_lvl),
    .skip_lvl  (skip_lvl),
    .hs_off_fb (hs_off_fb),
    .ls_off_fb (ls_off_fb),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
);

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       inhibit = 1'b0;
    logic [1:0] pwm = 2'b00;
    logic [1:0] skip = 2'b10;
    logic       zc = 1'b0;
    logic       hold_hs = 1'b0;
    logic       hold_ls = 1'b0;
    logic       hs_off_fb, ls_off_fb, hs_gate, ls_gate;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int overlaps = 0;

    typedef struct {
        int    at;
        logic  hs;
        logic  ls;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign hs_off_fb = !hs_gate && !hold_hs;
    assign ls_off_fb = !ls_gate && !hold_ls;

    hb_gate_seq i_hb_gate_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .inhibit   (inhibit),
        .pwm_lvl   (pwm),
        .skip_lvl  (skip),
        .zc_flag   (zc),
        .hs_off_fb (hs_off_fb),
        .ls_off_fb (ls_off_fb),
        .hs_gate   (hs_gate),
        .ls_gate   (ls_gate)
    );

    // monitor: pops expectations due this cycle and compares
    always @(posedge clk) begin
        #2;
        if (hs_gate && ls_gate) overlaps++;
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (hs_gate !== e.hs || ls_gate !== e.ls) begin
                errors++;
                $display("FAIL %s cycle %0d: hs/ls actual %b%b expected %b%b",
                         e.tag, cyc, hs_gate, ls_gate, e.hs, e.ls);
            end
        end
    end

    task automatic expect_at(int at, logic hs, logic ls, string tag);
        exp_t e;
        e.at = at; e.hs = hs; e.ls = ls; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic settle(logic [1:0] p, logic [1:0] s);
        @(negedge clk);
        pwm = p; skip = s;
        tick(8);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        finish_run();
    end

    initial begin
        int n;
        // R1 reset state
        tick(3);
        expect_at(cyc + 1, 0, 0, "R1 reset");
        tick(2);
        rst_n = 1'b1;
        tick(6);
        expect_at(cyc + 1, 0, 1, "R4 startup low");
        drain();

        // R3 high from low
        @(negedge clk); n = cyc; pwm = 2'b10;
        expect_at(n + 1, 0, 0, "R3 ls off");
        expect_at(n + 2, 0, 0, "R3 dead");
        expect_at(n + 3, 1, 0, "R3 hs on");
        drain();

        // R4 low from high
        @(negedge clk); n = cyc; pwm = 2'b00;
        expect_at(n + 1, 0, 0, "R4 hs off");
        expect_at(n + 2, 0, 0, "R4 dead");
        expect_at(n + 3, 0, 1, "R4 ls on");
        drain();

        // R3 feedback held: hs waits for reported low-side off
        @(negedge clk); n = cyc; hold_ls = 1'b1; pwm = 2'b10;
        expect_at(n + 1, 0, 0, "R3 ls off held");
        expect_at(n + 5, 0, 0, "R3 waits feedback");
        tick(5); hold_ls = 1'b0;
        expect_at(n + 6, 0, 0, "R3 dead after fb");
        expect_at(n + 7, 1, 0, "R3 hs on after fb");
        drain();

        // R5 mid with skip high: window then watch for zero cross
        settle(2'b10, 2'b10);
        @(negedge clk); n = cyc; pwm = 2'b01;
        expect_at(n + 1, 0, 0, "R5 hs off");
        expect_at(n + 3, 0, 1, "R5 ls on");
        expect_at(n + 35, 0, 1, "R5 window");
        expect_at(n + 36, 0, 1, "R5 watching");
        expect_at(n + 39, 0, 1, "R5 watching late");
        tick(39); zc = 1'b1;
        expect_at(n + 40, 0, 0, "R5 zero cross off");
        tick(1); zc = 1'b0;
        expect_at(n + 43, 0, 0, "R5 stays off");
        drain();

        // R6 + R7 early zero cross with skip mid
        settle(2'b10, 2'b01);
        @(negedge clk); n = cyc; pwm = 2'b01;
        expect_at(n + 3, 0, 1, "R7 ls on skip mid");
        expect_at(n + 11, 0, 1, "R6 early zc ignored");
        expect_at(n + 35, 0, 1, "R6 window held");
        expect_at(n + 36, 0, 0, "R6 off at window end");
        tick(10); zc = 1'b1;
        tick(1); zc = 1'b0;
        drain();

        // R5/R6 window from conducting low side, zc held through expiry
        settle(2'b00, 2'b10);
        @(negedge clk); n = cyc; pwm = 2'b01; zc = 1'b1;
        expect_at(n + 1, 0, 1, "R5 window from ls on");
        expect_at(n + 33, 0, 1, "R6 last window cycle");
        expect_at(n + 34, 0, 0, "R6 off right after window");
        drain();
        zc = 1'b0;

        // R8 skip low with mid
        settle(2'b10, 2'b10);
        @(negedge clk); n = cyc; pwm = 2'b01; skip = 2'b00;
        expect_at(n + 1, 0, 0, "R8 both off");
        expect_at(n + 4, 0, 0, "R8 stays off");
        drain();

        // R9 skip fall inside the window
        @(negedge clk); n = cyc; skip = 2'b10;
        expect_at(n + 5, 0, 1, "R9 ls on in window");
        tick(5); skip = 2'b00;
        expect_at(n + 6, 0, 0, "R9 skip fall off");
        expect_at(n + 9, 0, 0, "R9 stays off");
        drain();

        // R9 skip fall during continuous low
        settle(2'b00, 2'b10);
        @(negedge clk); n = cyc; skip = 2'b00;
        expect_at(n + 1, 0, 0, "R9 ls forced off");
        tick(3); skip = 2'b10;
        expect_at(n + 6, 0, 0, "R9 off until pwm change");
        drain();

        // R10 skip low while high side on
        settle(2'b10, 2'b10);
        @(negedge clk); n = cyc; skip = 2'b00;
        expect_at(n + 1, 1, 0, "R10 hs unaffected");
        expect_at(n + 4, 1, 0, "R10 hs still on");
        drain();

        // R11 abort window with pwm high
        settle(2'b10, 2'b10);
        @(negedge clk); n = cyc; pwm = 2'b01;
        expect_at(n + 3, 0, 1, "R11 window open");
        expect_at(n + 10, 0, 1, "R11 window still open");
        tick(10); pwm = 2'b10;
        expect_at(n + 11, 0, 0, "R11 ls dropped");
        expect_at(n + 12, 0, 0, "R11 dead");
        expect_at(n + 13, 1, 0, "R11 hs on");
        drain();

        // R1 inhibit and enable
        @(negedge clk); n = cyc; inhibit = 1'b1;
        expect_at(n + 1, 0, 0, "R1 inhibit off");
        expect_at(n + 3, 0, 0, "R1 inhibit held");
        tick(3); inhibit = 1'b0;
        expect_at(n + 5, 0, 0, "R1 restart dead");
        expect_at(n + 6, 1, 0, "R1 restart hs");
        drain();
        @(negedge clk); n = cyc; en = 1'b0;
        expect_at(n + 1, 0, 0, "R1 disable off");
        drain();
        en = 1'b1;

        // R2 randomized sequences
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            pwm  = 2'($urandom_range(0, 3));
            skip = 2'($urandom_range(0, 3));
            zc   = 1'($urandom_range(0, 1));
            tick($urandom_range(1, 40));
        end
        checks++;
        if (overlaps != 0) begin
            errors++;
            $display("FAIL R2 overlap: actual %0d cycles, expected 0", overlaps);
        end
        finish_run();
    end

endmodule